// File: doc/BRIEF.md
# Sticky Mismatch Comparator Chain with Serial Readout

This block is the response-checking half of a self-test arrangement for a programmable logic array. It holds one cell per pair of neighbouring blocks under test. On every self-test clock in which comparison is enabled, a cell compares the two outputs it watches. Any difference sets a flag in the cell, and that flag stays set until an explicit clear. Because the flags survive while comparison is switched off, several test phases can run back to back, and all of their results can be collected at the end.

After testing, the shift select turns the same flag flip-flops into a serial chain. Each shift clock moves every flag one cell toward the end of the chain, and the first cell takes the scan input. The last cell drives one chosen lane of the result bus. All other lanes of that bus are held at zero. The readout is a plain serial stream with no handshake. One bit advances per shift clock, so the reader applies back-pressure by leaving the shift select low. While the select is low, the chain holds its state and the output bit stays stable.

Top module: `ora_scan_top`

## Requirements
- R1: A cycle with `clr` high sets every flag to 0 at that clock edge.
- R2: In compare mode (`clr` low, `shift_en` low, `cmp_en` high), a cell whose `mon_a` and `mon_b` bits differ has its flag set to 1 at that clock edge, even if the difference lasts only one cycle.
- R3: In compare mode, a set flag stays 1 when the two monitored bits later agree.
- R4: With `clr`, `shift_en` and `cmp_en` all low, every flag keeps its value whatever `mon_a` and `mon_b` carry. This lets results persist from one test phase to the next.
- R5: In shift mode (`clr` low, `shift_en` high), cell i takes the old flag of cell i-1 and cell 0 takes `scan_in`. A full readout therefore delivers the flag of cell N_CELLS-1 first and the flag of cell 0 last, over N_CELLS shift clocks.
- R6: Bit `BUS_LANE` of `result_bus` always equals the flag of cell N_CELLS-1, and every other bit of `result_bus` is 0.
- R7: Priority is clear over shift over compare. A shift cycle ignores `cmp_en` and the monitored bits, and a clear cycle ignores `shift_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Self-test clock |
| clr | input | 1 | Synchronous clear of all flags |
| shift_en | input | 1 | Selects shift mode for readout |
| cmp_en | input | 1 | Enables comparison in compare mode |
| scan_in | input | 1 | Serial input into cell 0 |
| mon_a | input | N_CELLS | First monitored output, one bit per cell |
| mon_b | input | N_CELLS | Second monitored output, one bit per cell |
| result_bus | output | BUS_W | Result bus; only lane BUS_LANE carries the chain output |

## Verification
The bench builds the block with N_CELLS = 6, BUS_W = 8 and BUS_LANE = 3. With a short chain, every cell can receive its own single-cycle mismatch, and the test can confirm that each one appears at its own slot of a full readout. Placing the lane away from bit 0 exposes a driver that puts the serial bit on the wrong lane or leaks it onto other lanes. Six cells are also enough to give a one-step shift a distinct, non-symmetric pattern, and to shift in a bit sequence whose reversal would show up.

// File: rtl/ora_pkg.sv
package ora_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_COMPARE = 2'd1,
    MODE_SHIFT   = 2'd2,
    MODE_CLEAR   = 2'd3
  } ora_mode_e;

  // Clear wins over shift, shift wins over compare.
  function automatic ora_mode_e decode_mode(input logic clr,
                                            input logic shift_en,
                                            input logic cmp_en);
    ora_mode_e m;
    if (clr)           m = MODE_CLEAR;
    else if (shift_en) m = MODE_SHIFT;
    else if (cmp_en)   m = MODE_COMPARE;
    else               m = MODE_HOLD;
    return m;
  endfunction

endpackage

// File: rtl/ora_cell.sv
module ora_cell
  import ora_pkg::*;
(
  input  logic      clk,
  input  ora_mode_e mode,
  input  logic      mon_a,
  input  logic      mon_b,
  input  logic      chain_in,
  output logic      flag
);

  logic flag_q;
  logic diff;

  assign diff = mon_a ^ mon_b;

  always_ff @(posedge clk) begin
    unique case (mode)
      MODE_CLEAR:   flag_q <= 1'b0;
      MODE_SHIFT:   flag_q <= chain_in;
      MODE_COMPARE: flag_q <= flag_q | diff;
      default:      flag_q <= flag_q;
    endcase
  end

  assign flag = flag_q;

  // Assertion support: armed once a clear has been seen.
  logic armed;
  always_ff @(posedge clk) begin
    if (mode == MODE_CLEAR) armed <= 1'b1;
    else if (armed !== 1'b1) armed <= 1'b0;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (mode == MODE_CLEAR) |=> !flag); // R1
  AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (mode == MODE_COMPARE && mon_a != mon_b) |=> flag); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (mode == MODE_COMPARE && flag) |=> flag); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (mode == MODE_HOLD) |=> $stable(flag)); // R4

endmodule

// File: rtl/ora_chain.sv
module ora_chain
  import ora_pkg::*;
#(
  parameter int N_CELLS = 16
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               shift_en,
  input  logic               cmp_en,
  input  logic               scan_in,
  input  logic [N_CELLS-1:0] mon_a,
  input  logic [N_CELLS-1:0] mon_b,
  output logic [N_CELLS-1:0] flags,
  output logic               chain_out
);

  localparam int LAST = N_CELLS - 1;

  ora_mode_e mode;
  assign mode = decode_mode(clr, shift_en, cmp_en);

  logic [N_CELLS-1:0] link_in;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign link_in[i] = scan_in;
    end else begin : g_body
      assign link_in[i] = flags[i-1];
    end

    ora_cell u_cell (
      .clk      (clk),
      .mode     (mode),
      .mon_a    (mon_a[i]),
      .mon_b    (mon_b[i]),
      .chain_in (link_in[i]),
      .flag     (flags[i])
    );
  end

  assign chain_out = flags[LAST];

  logic armed;
  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
    else if (armed !== 1'b1) armed <= 1'b0;
  end

  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!clr && shift_en) |=> (flags[0] == $past(scan_in))); // R5
  AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!clr && shift_en) |=> (flags[N_CELLS-1:1] == $past(flags[N_CELLS-2:0]))); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    clr |=> ($countones(flags) == 0)); // R7

endmodule

// File: rtl/ora_bus_lane.sv
module ora_bus_lane #(
  parameter int BUS_W    = 8,
  parameter int BUS_LANE = 0
) (
  input  logic             bit_in,
  output logic [BUS_W-1:0] bus_out
);

  for (genvar j = 0; j < BUS_W; j++) begin : g_lane
    if (j == BUS_LANE) begin : g_live
      assign bus_out[j] = bit_in;
    end else begin : g_tied
      assign bus_out[j] = 1'b0;
    end
  end

  always_comb begin
    AST_LANE_ONLY: assert ($countones(bus_out) <= 1); // R6
  end

endmodule

// File: rtl/ora_scan_top.sv
module ora_scan_top #(
  parameter int N_CELLS  = 16,
  parameter int BUS_W    = 8,
  parameter int BUS_LANE = 0
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               shift_en,
  input  logic               cmp_en,
  input  logic               scan_in,
  input  logic [N_CELLS-1:0] mon_a,
  input  logic [N_CELLS-1:0] mon_b,
  output logic [BUS_W-1:0]   result_bus
);

  logic [N_CELLS-1:0] flags;
  logic               chain_out;

  ora_chain #(.N_CELLS(N_CELLS)) u_chain (
    .clk       (clk),
    .clr       (clr),
    .shift_en  (shift_en),
    .cmp_en    (cmp_en),
    .scan_in   (scan_in),
    .mon_a     (mon_a),
    .mon_b     (mon_b),
    .flags     (flags),
    .chain_out (chain_out)
  );

  ora_bus_lane #(.BUS_W(BUS_W), .BUS_LANE(BUS_LANE)) u_lane (
    .bit_in  (chain_out),
    .bus_out (result_bus)
  );

  always_comb begin
    AST_LANE_TRACKS_TAIL: assert (result_bus[BUS_LANE] == flags[N_CELLS-1]); // R6
  end

endmodule

// File: tb/ora_scan_top_tb_top.sv
module ora_scan_top_tb_top;

  localparam int N        = 6;
  localparam int BW       = 8;
  localparam int LANE     = 3;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          clr, shift_en, cmp_en, scan_in;
  logic [N-1:0]  mon_a, mon_b;
  logic [BW-1:0] result_bus;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PER/2) clk = ~clk;

  ora_scan_top #(.N_CELLS(N), .BUS_W(BW), .BUS_LANE(LANE)) dut_i (
    .clk(clk), .clr(clr), .shift_en(shift_en), .cmp_en(cmp_en),
    .scan_in(scan_in), .mon_a(mon_a), .mon_b(mon_b), .result_bus(result_bus)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    clr = 0; shift_en = 0; cmp_en = 0; scan_in = 0; mon_a = '0; mon_b = '0;
  endtask

  task automatic do_clear();
    idle_inputs(); clr = 1; tick(); clr = 0;
  endtask

  // Full readout: N samples, shifting between them; lane purity checked each sample.
  task automatic read_chain(output logic [N-1:0] got);
    idle_inputs();
    for (int k = 0; k < N; k++) begin
      check("R6 other lanes zero", 32'(result_bus & ~(BW'(1) << LANE)), 32'd0);
      got[N-1-k] = result_bus[LANE];
      shift_en = 1; tick(); shift_en = 0;
    end
  endtask

  task automatic t_reset();
    logic [N-1:0] got;
    do_clear();
    check("R1 bus after clear", 32'(result_bus), 32'd0);
    read_chain(got);
    check("R1 all flags clear", 32'(got), 32'd0);
  endtask

  task automatic t_single(input int c);
    logic [N-1:0] got;
    do_clear();
    cmp_en = 1;
    mon_a = N'(1) << c; mon_b = '0; tick();
    mon_a = '1; mon_b = '1; tick(); tick();
    mon_a = '0; mon_b = '0; tick();
    read_chain(got);
    check($sformatf("R2/R3 single mismatch cell %0d", c), 32'(got), 32'(N'(1) << c));
  endtask

  task automatic t_no_enable();
    logic [N-1:0] got;
    do_clear();
    mon_a = '1; mon_b = '0; tick(); tick();
    read_chain(got);
    check("R4 mismatch ignored when compare off", 32'(got), 32'd0);
  endtask

  task automatic t_phases();
    logic [N-1:0] got;
    do_clear();
    cmp_en = 1; mon_a = 6'b000010; mon_b = '0; tick();
    cmp_en = 0; mon_a = '1; mon_b = '0; tick(); tick();
    check("R4 hold keeps tail flag", 32'(result_bus[LANE]), 32'd0);
    cmp_en = 1; mon_a = '0; mon_b = 6'b010000; tick();
    mon_b = '0; tick();
    read_chain(got);
    check("R3/R4 flags persist across phases", 32'(got), 32'(6'b010010));
  endtask

  task automatic t_shift_in();
    logic [N-1:0] pat, got, exp;
    pat = 6'b110100;
    do_clear();
    shift_en = 1; cmp_en = 1; mon_a = '1; mon_b = '0;
    for (int k = 0; k < N; k++) begin
      scan_in = pat[k]; tick();
    end
    idle_inputs();
    for (int k = 0; k < N; k++) exp[N-1-k] = pat[k];
    read_chain(got);
    check("R5/R7 shifted-in order, compare ignored", 32'(got), 32'(exp));
  endtask

  task automatic t_one_step();
    logic [N-1:0] got;
    do_clear();
    cmp_en = 1; mon_a = 6'b000101; tick();
    idle_inputs();
    shift_en = 1; scan_in = 1; tick();
    idle_inputs();
    read_chain(got);
    check("R5 one shift step", 32'(got), 32'(6'b001011));
  endtask

  task automatic t_tail_visible();
    do_clear();
    cmp_en = 1; mon_a = 6'b100000; tick();
    idle_inputs();
    check("R6 lane shows tail flag", 32'(result_bus), 32'(BW'(1) << LANE));
  endtask

  task automatic t_clear_wins();
    logic [N-1:0] got;
    do_clear();
    cmp_en = 1; mon_a = '1; tick();
    clr = 1; shift_en = 1; scan_in = 1; cmp_en = 1; mon_a = '1; mon_b = '0; tick();
    idle_inputs();
    read_chain(got);
    check("R7 clear beats shift and compare", 32'(got), 32'd0);
  endtask

  initial begin
    idle_inputs();
    clr = 1;
    @(negedge clk);
    t_reset();
    for (int c = 0; c < N; c++) t_single(c);
    t_no_enable();
    t_phases();
    t_shift_in();
    t_one_step();
    t_tail_visible();
    t_clear_wins();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule